// File: doc/BRIEF.md
# Dual Capture/Compare Free-Running Timer

This block is a free-running up-counter with two compare outputs and two capture inputs, reached over a small synchronous register port. Each compare channel owns a compare register and an output latch that drives a pin. When the counter reaches the compare value, the latch takes a level that software has set in advance. Software can also push that level into the latch at once with a write-only force bit. A forced load leaves the compare flag alone.

Each capture channel passes its pin through a synchronizer and watches for an edge. When the edge arrives, the channel stores the counter value and raises its flag. The first channel lets software pick the rising or the falling edge. The second channel reacts to falling edges only. Five flags (two compare, two capture, one overflow) are cleared by writing ones. Each flag has an enable, and a single interrupt line is high while any enabled flag is set.

Writes take effect on the clock edge that samples `bus_wr` high. Reads are combinational from `bus_addr`. Register addresses: 0 control, 1 status, 2 counter (read-only), 3 compare A, 4 compare B, 5 capture A (read-only), 6 capture B (read-only). The counter, compare and capture values are zero-extended onto the data bus.

Top module: `dcc_timer`

## Requirements
- R1: The counter adds one on every clock after reset and wraps from all-ones to zero. The edge that performs the wrap sets the overflow flag, status bit 4. The counter reads back at address 2.
- R2: While the counter equals a compare register (address 3 for channel A, 4 for channel B), the next clock edge loads that channel's level bit into its output latch and sets its compare flag. Level bits are control bit 0 (A) and control bit 1 (B); 1 drives the pin high. Compare flags are status bit 0 (A) and status bit 1 (B).
- R3: Writing control with bit 3 (A) or bit 4 (B) set loads the level bit carried in that same write into the channel's output latch on that clock edge. Force bits always read back as zero.
- R4: A forced load never sets the compare flag of its channel.
- R5: A control write with the force bits at zero leaves both output pins unchanged, even when it changes the level bits.
- R6: Capture A uses the edge chosen by control bit 2: 1 selects rising, 0 selects falling. The other edge is ignored. On the chosen edge the channel stores the counter value held SYNC_STAGES clocks after the pin change into capture A (address 5) and sets status bit 2.
- R7: Capture B reacts only to falling edges. It then stores the counter value as in R6 into address 6 and sets status bit 3. A rising edge changes neither status bit 3 nor the capture B register.
- R8: Writing status clears each flag whose data bit is 1. Data bits that are 0 leave their flags unchanged. A flag that is set and cleared in the same cycle stays set.
- R9: `irq` is high exactly while some status flag i is set together with its enable, control bit 8+i.
- R10: In reset, the counter, all flags, the control register and both output pins are zero. Capture A therefore starts in falling-edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| cap_a_pin | input | 1 | Capture channel A input, asynchronous |
| cap_b_pin | input | 1 | Capture channel B input, asynchronous, falling edge only |
| cmp_a_pin | output | 1 | Compare channel A output latch |
| cmp_b_pin | output | 1 | Compare channel B output latch |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the timer with CNT_W = 8, DATA_W = 16 and SYNC_STAGES = 2. With an 8-bit counter the wrap comes every 256 cycles, so the bench can sweep all 256 compare values on channel A, with alternating levels, and still have time left for overflow and interrupt cases. With a two-stage synchronizer the captured value is exactly the counter at the pin change plus two. That value is checked for both edge polarities on A and on B across varying start phases, and the ignored edge is checked on each channel.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [2:0] {
      A_CTRL  = 3'd0,
      A_STAT  = 3'd1,
      A_COUNT = 3'd2,
      A_CMPA  = 3'd3,
      A_CMPB  = 3'd4,
      A_CAPA  = 3'd5,
      A_CAPB  = 3'd6
   } reg_addr_e;

   localparam int NUM_FLAGS  = 5;
   localparam int CB_LVL     = 0;   // two bits, one per compare channel
   localparam int CB_EDGE_A  = 2;
   localparam int CB_FORCE   = 3;   // two bits, one per compare channel
   localparam int CB_IE      = 8;   // NUM_FLAGS enable bits
   localparam int FB_CMP     = 0;
   localparam int FB_CAP     = 2;
   localparam int FB_OVF     = 4;
   localparam int CTRL_BITS  = CB_IE + NUM_FLAGS;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   output logic [W-1:0] cnt,
   output logic         ovf_flag
);
   localparam logic [W-1:0] CNT_MAX = '1;

   if (W < 2) begin : g_bad_w
      $error("tmr_counter: W must be at least 2");
   end

   logic wrap;
   assign wrap = (cnt == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         ovf_flag <= 1'b0;
      end else begin
         cnt <= cnt + 1'b1;
         if (wrap)     ovf_flag <= 1'b1;
         else if (clr) ovf_flag <= 1'b0;
      end
   end

   // R1
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |-> (cnt == W'($past(cnt) + 1'b1)));
   // R1
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && cnt == CNT_MAX) |=> (cnt == '0 && ovf_flag));
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] cmp_val,
   input  logic         lvl,
   input  logic         force_en,
   input  logic         force_val,
   input  logic         clr,
   output logic         pin_out,
   output logic         flag
);
   if (W < 2) begin : g_bad_w
      $error("tmr_compare: W must be at least 2");
   end

   logic match;
   assign match = (cnt == cmp_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_out <= 1'b0;
         flag    <= 1'b0;
      end else begin
         if (force_en)   pin_out <= force_val;
         else if (match) pin_out <= lvl;
         if (match)      flag <= 1'b1;
         else if (clr)   flag <= 1'b0;
      end
   end

   // R2
   cmp_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && match && !force_en) |=> (pin_out == $past(lvl) && flag));
   // R3
   force_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && force_en) |=> (pin_out == $past(force_val)));
   // R4
   force_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && force_en && !match && !flag) |=> !flag);
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
   parameter int W           = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit EDGE_SEL    = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pin,
   input  logic         rise_sel,
   input  logic [W-1:0] cnt,
   input  logic         clr,
   output logic [W-1:0] cap_val,
   output logic         flag
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tmr_capture: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES:0] sh;
   logic synced, prev, rise, fall, fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[SYNC_STAGES-1:0], pin};
   end

   assign synced = sh[SYNC_STAGES-1];
   assign prev   = sh[SYNC_STAGES];
   assign rise   = synced & ~prev;
   assign fall   = ~synced & prev;

   if (EDGE_SEL) begin : g_sel
      assign fire = rise_sel ? rise : fall;
   end else begin : g_fixed
      logic unused_sel;
      assign unused_sel = rise_sel;
      assign fire = fall;
      // R7
      fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rst_n && rise && !clr) |=> (flag == $past(flag) && $stable(cap_val)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_val <= '0;
         flag    <= 1'b0;
      end else begin
         if (fire) cap_val <= cnt;
         if (fire)     flag <= 1'b1;
         else if (clr) flag <= 1'b0;
      end
   end

   // R6
   cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && fire) |=> (cap_val == $past(cnt) && flag));
endmodule

// File: rtl/dcc_timer.sv
module dcc_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              cap_a_pin,
   input  logic              cap_b_pin,
   output logic              cmp_a_pin,
   output logic              cmp_b_pin,
   output logic              irq
);
   localparam int NCH = 2;

   if (DATA_W < CTRL_BITS || DATA_W < CNT_W) begin : g_bad_data
      $error("dcc_timer: DATA_W too narrow for control or counter");
   end

   logic [NCH-1:0]       lvl_q;
   logic                 edge_a_q;
   logic [NUM_FLAGS-1:0] ie_q;
   logic [NUM_FLAGS-1:0] flags;
   logic [NUM_FLAGS-1:0] clr;
   logic [CNT_W-1:0]     cnt;
   logic [CNT_W-1:0]     cmp_q [NCH];
   logic [CNT_W-1:0]     cap_q [NCH];
   logic [NCH-1:0]       force_en, force_val, cmp_out, cap_in;
   logic                 wr_ctrl, wr_stat;

   assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
   assign wr_stat = bus_wr && (bus_addr == A_STAT);
   assign clr     = wr_stat ? bus_wdata[NUM_FLAGS-1:0] : '0;
   assign cap_in  = {cap_b_pin, cap_a_pin};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q    <= '0;
         edge_a_q <= 1'b0;
         ie_q     <= '0;
      end else if (wr_ctrl) begin
         lvl_q    <= bus_wdata[CB_LVL +: NCH];
         edge_a_q <= bus_wdata[CB_EDGE_A];
         ie_q     <= bus_wdata[CB_IE +: NUM_FLAGS];
      end
   end

   tmr_counter #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr[FB_OVF]),
      .cnt      (cnt),
      .ovf_flag (flags[FB_OVF])
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cmp_q[i] <= '0;
         else if (bus_wr && bus_addr == 3'(A_CMPA + i))
            cmp_q[i] <= bus_wdata[CNT_W-1:0];
      end

      assign force_en[i]  = wr_ctrl & bus_wdata[CB_FORCE + i];
      assign force_val[i] = bus_wdata[CB_LVL + i];

      tmr_compare #(.W(CNT_W)) u_cmp (
         .clk       (clk),
         .rst_n     (rst_n),
         .cnt       (cnt),
         .cmp_val   (cmp_q[i]),
         .lvl       (lvl_q[i]),
         .force_en  (force_en[i]),
         .force_val (force_val[i]),
         .clr       (clr[FB_CMP + i]),
         .pin_out   (cmp_out[i]),
         .flag      (flags[FB_CMP + i])
      );

      tmr_capture #(.W(CNT_W), .SYNC_STAGES(SYNC_STAGES), .EDGE_SEL(i == 0)) u_cap (
         .clk      (clk),
         .rst_n    (rst_n),
         .pin      (cap_in[i]),
         .rise_sel (edge_a_q),
         .cnt      (cnt),
         .clr      (clr[FB_CAP + i]),
         .cap_val  (cap_q[i]),
         .flag     (flags[FB_CAP + i])
      );
   end

   assign cmp_a_pin = cmp_out[0];
   assign cmp_b_pin = cmp_out[1];
   assign irq       = |(flags & ie_q);

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CTRL: begin
            bus_rdata[CB_LVL +: NCH]      = lvl_q;
            bus_rdata[CB_EDGE_A]          = edge_a_q;
            bus_rdata[CB_IE +: NUM_FLAGS] = ie_q;
         end
         A_STAT:  bus_rdata[NUM_FLAGS-1:0] = flags;
         A_COUNT: bus_rdata[CNT_W-1:0]     = cnt;
         A_CMPA:  bus_rdata[CNT_W-1:0]     = cmp_q[0];
         A_CMPB:  bus_rdata[CNT_W-1:0]     = cmp_q[1];
         A_CAPA:  bus_rdata[CNT_W-1:0]     = cap_q[0];
         A_CAPB:  bus_rdata[CNT_W-1:0]     = cap_q[1];
         default: bus_rdata = '0;
      endcase
   end

   // R3
   force_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_CTRL) |-> (bus_rdata[CB_FORCE +: NCH] == '0));
   // R9
   irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && flags == '0) |-> !irq);
endmodule

// File: tb/sim_dcc_timer.sv
module sim_dcc_timer;
   localparam int CW = 8;
   localparam int SS = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        cap_a_pin = 1'b0, cap_b_pin = 1'b0;
   logic        cmp_a_pin, cmp_b_pin, irq;

   int total = 0, bad = 0;
   bit done = 1'b0;
   logic [CW-1:0] ecnt;

   dcc_timer #(.CNT_W(CW), .DATA_W(16), .SYNC_STAGES(SS)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_a_pin(cap_a_pin),
      .cap_b_pin(cap_b_pin), .cmp_a_pin(cmp_a_pin), .cmp_b_pin(cmp_b_pin), .irq(irq));

   always #5 clk = ~clk;

   always @(posedge clk or negedge rst_n)
      if (!rst_n) ecnt <= '0;
      else        ecnt <= ecnt + 1'b1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_cnt(input logic [CW-1:0] x);
      while (ecnt != x) @(negedge clk);
   endtask

   task automatic step(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      logic [15:0] ctrl;
      logic        exp_a;
      logic [CW-1:0] c0, prevcap;

      step(3);
      // R10 reset state
      rd(3'd0, d); chk(d == 0, "R10 ctrl", d, 0);
      rd(3'd1, d); chk(d == 0, "R10 stat", d, 0);
      rd(3'd2, d); chk(d == 0, "R10 count", d, 0);
      chk({cmp_a_pin, cmp_b_pin, irq} == 0, "R10 pins", {cmp_a_pin, cmp_b_pin, irq}, 0);
      rst_n = 1'b1;

      // R1 counter and overflow
      step(5);
      rd(3'd2, d); chk(d == 16'(ecnt), "R1 count", d, ecnt);
      wait_cnt(8'hFF);
      rd(3'd2, d); chk(d == 16'hFF, "R1 count max", d, 16'hFF);
      rd(3'd1, d); chk(d[4] == 1'b0, "R1 ovf before wrap", d[4], 0);
      step(1);
      rd(3'd2, d); chk(d == 0, "R1 wrap", d, 0);
      rd(3'd1, d); chk(d[4] == 1'b1, "R1 ovf after wrap", d[4], 1);
      // R8 write-one-to-clear
      wr(3'd1, 16'h0000);
      rd(3'd1, d); chk(d[4] == 1'b1, "R8 zero write keeps", d[4], 1);
      wr(3'd1, 16'h0010);
      rd(3'd1, d); chk(d[4] == 1'b0, "R8 one write clears", d[4], 0);

      // R2 sweep of all compare values on channel A
      ctrl = '0;
      exp_a = 1'b0;
      for (int i = 0; i < 256; i++) begin
         logic lv;
         logic [CW-1:0] m;
         m = CW'(i);
         lv = ~i[0];
         wait_cnt(m + 8'd8);
         ctrl[0] = lv;
         wr(3'd0, ctrl);
         wr(3'd3, 16'(m));
         wr(3'd1, 16'h0001);
         wait_cnt(m);
         chk(cmp_a_pin == exp_a, "R2 pin before match", cmp_a_pin, exp_a);
         rd(3'd1, d); chk(d[0] == 1'b0, "R2 flag before match", d[0], 0);
         step(1);
         exp_a = lv;
         chk(cmp_a_pin == exp_a, "R2 pin after match", cmp_a_pin, exp_a);
         rd(3'd1, d); chk(d[0] == 1'b1, "R2 flag after match", d[0], 1);
      end
      // R2 channel B subset
      for (int i = 0; i < 16; i++) begin
         logic lv;
         logic [CW-1:0] m;
         m = CW'(i * 16 + 5);
         lv = i[0];
         wait_cnt(m + 8'd8);
         ctrl[1] = lv;
         wr(3'd0, ctrl);
         wr(3'd4, 16'(m));
         wr(3'd1, 16'h0002);
         wait_cnt(m);
         rd(3'd1, d); chk(d[1] == 1'b0, "R2 B flag before", d[1], 0);
         step(1);
         chk(cmp_b_pin == lv, "R2 B pin after match", cmp_b_pin, lv);
         rd(3'd1, d); chk(d[1] == 1'b1, "R2 B flag after", d[1], 1);
      end

      // R3 R4 R5 forcing
      wr(3'd3, 16'(ecnt + 8'd120));
      wr(3'd4, 16'(ecnt + 8'd120));
      wr(3'd1, 16'h0003);
      ctrl[1:0] = 2'b00;
      wr(3'd0, ctrl);
      wr(3'd0, ctrl | 16'h0008);     // force A to 0
      chk(cmp_a_pin == 1'b0, "R3 force A low", cmp_a_pin, 0);
      wr(3'd0, ctrl | 16'h0009);     // force A to 1
      chk(cmp_a_pin == 1'b1, "R3 force A high", cmp_a_pin, 1);
      rd(3'd1, d); chk(d[0] == 1'b0, "R4 no flag A", d[0], 0);
      rd(3'd0, d); chk(d[4:3] == 2'b00, "R3 force reads zero", d[4:3], 0);
      chk(d[0] == 1'b1, "R3 level kept", d[0], 1);
      wr(3'd0, ctrl);                // level 0, no force
      chk(cmp_a_pin == 1'b1, "R5 A unchanged", cmp_a_pin, 1);
      wr(3'd0, ctrl | 16'h0012);     // force B to 1
      chk(cmp_b_pin == 1'b1, "R3 force B high", cmp_b_pin, 1);
      chk(cmp_a_pin == 1'b1, "R5 A untouched by B force", cmp_a_pin, 1);
      rd(3'd1, d); chk(d[1:0] == 2'b00, "R4 no flags", d[1:0], 0);
      wr(3'd0, ctrl | 16'h0003);     // levels 1, no force
      wr(3'd0, ctrl);
      chk(cmp_b_pin == 1'b1, "R5 B unchanged", cmp_b_pin, 1);
      wr(3'd0, ctrl | 16'h0018);     // force both to 0
      chk({cmp_a_pin, cmp_b_pin} == 2'b00, "R3 force both low", {cmp_a_pin, cmp_b_pin}, 0);

      // R6 capture A, both modes, varied phase
      for (int i = 0; i < 8; i++) begin
         ctrl[2] = 1'b0;
         wr(3'd0, ctrl);
         wr(3'd1, 16'h0004);
         rd(3'd5, d); prevcap = d[CW-1:0];
         step(i);
         cap_a_pin = 1'b1;           // rising: ignored in falling mode
         step(5);
         rd(3'd1, d); chk(d[2] == 1'b0, "R6 rise ignored flag", d[2], 0);
         rd(3'd5, d); chk(d[CW-1:0] == prevcap, "R6 rise ignored value", d, prevcap);
         c0 = ecnt;
         cap_a_pin = 1'b0;
         step(4);
         rd(3'd1, d); chk(d[2] == 1'b1, "R6 fall flag", d[2], 1);
         rd(3'd5, d); chk(d[CW-1:0] == CW'(c0 + SS), "R6 fall value", d, c0 + SS);
         ctrl[2] = 1'b1;
         wr(3'd0, ctrl);
         wr(3'd1, 16'h0004);
         step(i + 1);
         c0 = ecnt;
         cap_a_pin = 1'b1;
         step(4);
         rd(3'd1, d); chk(d[2] == 1'b1, "R6 rise flag", d[2], 1);
         rd(3'd5, d); chk(d[CW-1:0] == CW'(c0 + SS), "R6 rise value", d, c0 + SS);
         prevcap = d[CW-1:0];
         wr(3'd1, 16'h0004);
         cap_a_pin = 1'b0;           // falling: ignored in rising mode
         step(5);
         rd(3'd1, d); chk(d[2] == 1'b0, "R6 fall ignored flag", d[2], 0);
         rd(3'd5, d); chk(d[CW-1:0] == prevcap, "R6 fall ignored value", d, prevcap);
      end

      // R7 capture B falling only, in either A mode
      for (int i = 0; i < 8; i++) begin
         ctrl[2] = i[0];
         wr(3'd0, ctrl);
         wr(3'd1, 16'h0008);
         rd(3'd6, d); prevcap = d[CW-1:0];
         step(i);
         cap_b_pin = 1'b1;
         step(5);
         rd(3'd1, d); chk(d[3] == 1'b0, "R7 rise ignored flag", d[3], 0);
         rd(3'd6, d); chk(d[CW-1:0] == prevcap, "R7 rise ignored value", d, prevcap);
         c0 = ecnt;
         cap_b_pin = 1'b0;
         step(4);
         rd(3'd1, d); chk(d[3] == 1'b1, "R7 fall flag", d[3], 1);
         rd(3'd6, d); chk(d[CW-1:0] == CW'(c0 + SS), "R7 fall value", d, c0 + SS);
      end

      // R9 interrupt masking
      ctrl = 16'h0400;               // enable capture A only, falling mode
      wr(3'd0, ctrl);
      wr(3'd1, 16'h001F);
      chk(irq == 1'b0, "R9 irq idle", irq, 0);
      cap_a_pin = 1'b1;
      step(4);
      chk(irq == 1'b0, "R9 irq masked edge", irq, 0);
      cap_a_pin = 1'b0;
      step(4);
      chk(irq == 1'b1, "R9 irq on capture", irq, 1);
      wr(3'd1, 16'h0004);
      chk(irq == 1'b0, "R9 irq cleared", irq, 0);
      ctrl = 16'h1000;               // enable overflow only
      wr(3'd0, ctrl);
      wr(3'd1, 16'h001F);
      wait_cnt(8'hFF);
      chk(irq == 1'b0, "R9 irq before wrap", irq, 0);
      step(1);
      chk(irq == 1'b1, "R9 irq on overflow", irq, 1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule